// File: doc/BRIEF.md
# Audio Clock Ratio Detector

This block runs on a free-running system clock and watches the audio word clock and bit clock, which are assumed to be synchronous to it. It finds out, without any configuration input, how many system clock cycles make up one audio sample period. It reports that ratio as one of six supported oversampling multiples. Downstream conversion logic uses the ready flag to know that the clocking is valid. It uses the force-to-mid-scale flag to replace its samples with the bipolar-zero code whenever the clocking cannot be trusted.

After the reset input is released, a fixed start-up sequence runs for 1024 system clock cycles. During that time nothing is measured. The block then measures the spacing of word-clock rising edges and locks once two consecutive frames agree. While locked, it counts bit-clock edges per frame against the count learned at lock. A shift of the word clock by more than six bit-clock periods, or a word clock that stops, drops the lock. The drop produces a one-cycle resync pulse and starts a fresh acquisition.

Top module: `audio_clk_ratio_det`

## Requirements
- R1: Reset is synchronous and active low. While reset is applied and for the 1024 clock cycles after its release, ratio_ready is 0, force_mid is 1 and resync_pulse is 0. ratio_code is 0 after reset.
- R2: A frame is the number of clk cycles from one sampled rising edge of word_clk to the next. The frame matches a ratio when it lies within plus or minus 2 cycles of that ratio. The codes are 0=128, 1=192, 2=256, 3=384, 4=512 and 5=768. The locked code appears on ratio_code.
- R3: Lock requires two consecutive frames that match the same ratio. ratio_ready rises one cycle after the clock edge at which the rising edge of word_clk ending the second such frame is sampled. Frames that alternate between two ratios never lock. ratio_code holds its value while ratio_ready is 1.
- R4: A frame that matches no ratio discards any pending candidate. With such a clock, ratio_ready stays 0.
- R5: force_mid is 1 whenever ratio_ready is 0, and 0 whenever ratio_ready is 1.
- R6: While locked, each rising edge of word_clk compares the number of bit_clk rising edges in the frame just ended with the number learned at lock. A difference of more than 6 drops the lock. A difference of 6 or less keeps it.
- R7: While locked, the lock also drops without waiting for a word_clk edge in two cases. One is a bit_clk count since the last word_clk edge that exceeds the learned count by more than 6. The other is more than 770 clk cycles since that edge.
- R8: Losing lock lowers ratio_ready and raises resync_pulse for exactly one cycle, at the same clock edge. A new acquisition under R3 follows, without repeating the 1024-cycle start-up. When the loss happens at a word_clk edge, that edge starts the first new frame.
- R9: Applying reset at any time, including while locked, clears the lock and restarts the full 1024-cycle start-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| word_clk | input | 1 | Audio word (frame) clock, synchronous to clk |
| bit_clk | input | 1 | Audio bit clock, synchronous to clk |
| ratio_code | output | 3 | Detected ratio code (0..5, ascending ratio) |
| ratio_ready | output | 1 | Ratio locked and clocking valid |
| force_mid | output | 1 | Force output samples to bipolar zero |
| resync_pulse | output | 1 | One-cycle pulse when lock is lost |

## Verification
The bench targets the match window edges at 126 and 258 cycles, which must lock, and 259 and 300 cycles, which must not. An off-by-one window would lock where it should not, or miss a lock. Word-clock jumps of exactly six and seven bit periods check the drift threshold. A wrong comparison would either drop a healthy lock or keep a shifted one. A word clock held low with the bit clock running, and both clocks frozen, check the two paths that drop a lock without an edge. Without them a dead clock would stay ready forever. Frames alternating between 256 and 384 cycles show that one matching frame is not enough to lock. A reset while locked shows that the start-up sequence runs again, not a bare relock.

// File: rtl/acd_pkg.sv
// Shared constants, types and the ratio table for the clock ratio detector.
// Assumes six ratios, built from a base ratio as 1x,1.5x,2x,3x,4x,6x.
package acd_pkg;
    localparam int NUM_RATIOS = 6;
    localparam int CODE_W     = 3;

    typedef logic [CODE_W-1:0] ratio_code_t;

    typedef enum logic {
        DET_ACQUIRE = 1'b0,
        DET_LOCKED  = 1'b1
    } det_state_t;

    // Ratio for a given code: even codes are base<<k, odd codes 1.5*base<<k.
    function automatic int ratio_of(input int base, input int idx);
        int r;
        r = ((idx % 2) == 0) ? base : (base * 3) / 2;
        return r << (idx / 2);
    endfunction
endpackage

// File: rtl/acd_init_seq.sv
// Start-up sequencer: counts INIT_CYCLES clocks after reset release, then
// raises init_done and keeps it high until the next reset.
// Assumes a synchronous active-low reset.
module acd_init_seq #(
    parameter int INIT_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    output logic init_done
);
    localparam int CNT_W = $clog2(INIT_CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    // Count the start-up cycles, flag completion on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            init_done <= 1'b0;
        end else if (!init_done) begin
            if (cnt == CNT_W'(INIT_CYCLES - 1)) begin
                init_done <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_INIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) init_done |=> init_done); // R1
endmodule

// File: rtl/acd_frame_meter.sv
// Frame meter: detects rising edges of the word and bit clocks (both
// synchronous to clk) and measures, per frame, the clk cycle count and the
// bit clock rising-edge count. Counters saturate and stay cleared until run.
module acd_frame_meter #(
    parameter int PER_W = 11,
    parameter int BIT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             word_clk,
    input  logic             bit_clk,
    output logic             word_rise,
    output logic [PER_W-1:0] per_cnt,
    output logic [BIT_W-1:0] bit_cnt
);
    localparam logic [PER_W-1:0] PER_MAX = '1;
    localparam logic [BIT_W-1:0] BIT_MAX = '1;

    logic word_q;
    logic bit_q;
    logic bit_rise;

    // Keep the previous sample of each clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= 1'b0;
            bit_q  <= 1'b0;
        end else begin
            word_q <= word_clk;
            bit_q  <= bit_clk;
        end
    end

    assign word_rise = word_clk & ~word_q;
    assign bit_rise  = bit_clk & ~bit_q;

    // Frame length and bit count, restarted on every word clock rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_cnt <= '0;
            bit_cnt <= '0;
        end else if (!run) begin
            per_cnt <= '0;
            bit_cnt <= '0;
        end else if (word_rise) begin
            per_cnt <= PER_W'(1);
            bit_cnt <= BIT_W'(bit_rise);
        end else begin
            if (per_cnt != PER_MAX) begin
                per_cnt <= per_cnt + 1'b1;
            end
            if (bit_rise && (bit_cnt != BIT_MAX)) begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    AST_PER_RESTART: assert property (@(posedge clk) disable iff (!rst_n) (run && word_rise) |=> (per_cnt == PER_W'(1))); // R2
endmodule

// File: rtl/acd_ratio_match.sv
// Ratio matcher: compares a frame length against every supported ratio with
// a symmetric tolerance and returns the matching code. Assumes TOL is small
// enough that at most one window can match.
module acd_ratio_match
    import acd_pkg::*;
#(
    parameter int BASE_RATIO = 128,
    parameter int TOL        = 2,
    parameter int PER_W      = 11
) (
    input  logic [PER_W-1:0] per_cnt,
    output logic             match_valid,
    output ratio_code_t      match_code
);
    logic [NUM_RATIOS-1:0] hit;

    for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_window
        localparam int RV = ratio_of(BASE_RATIO, i);
        assign hit[i] = (per_cnt >= PER_W'(RV - TOL)) && (per_cnt <= PER_W'(RV + TOL));
    end

    // Encode the matching window into its code.
    always_comb begin
        match_code  = '0;
        match_valid = |hit;
        for (int i = 0; i < NUM_RATIOS; i++) begin
            if (hit[i]) begin
                match_code = CODE_W'(i);
            end
        end
    end
endmodule

// File: rtl/acd_lock_ctrl.sv
// Lock controller: acquires a ratio from two consecutive matching frames,
// then guards the lock using the bit clock count per frame and a timeout.
// On loss it pulses resync and restarts acquisition. Idle until init_done.
module acd_lock_ctrl
    import acd_pkg::*;
#(
    parameter int PER_W      = 11,
    parameter int BIT_W      = 8,
    parameter int DRIFT_BITS = 6,
    parameter int PER_LIMIT  = 770
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_done,
    input  logic             word_rise,
    input  logic [PER_W-1:0] per_cnt,
    input  logic [BIT_W-1:0] bit_cnt,
    input  logic             match_valid,
    input  ratio_code_t      match_code,
    output logic             locked,
    output ratio_code_t      ratio_code,
    output logic             resync
);
    det_state_t       state;
    logic             have_ref;
    logic             cand_valid;
    ratio_code_t      cand_code;
    logic [BIT_W-1:0] bit_ref;
    logic [BIT_W:0]   bit_diff;
    logic             drift_bad;
    logic             late_bad;

    assign locked = (state == DET_LOCKED);

    // Distance of this frame's bit count from the learned one, and timeouts.
    always_comb begin
        bit_diff  = (bit_cnt >= bit_ref) ? {1'b0, bit_cnt - bit_ref} : {1'b0, bit_ref - bit_cnt};
        drift_bad = bit_diff > (BIT_W + 1)'(DRIFT_BITS);
        late_bad  = ({1'b0, bit_cnt} > ({1'b0, bit_ref} + (BIT_W + 1)'(DRIFT_BITS)))
                 || (per_cnt > PER_W'(PER_LIMIT));
    end

    // Acquisition and lock supervision state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= DET_ACQUIRE;
            have_ref   <= 1'b0;
            cand_valid <= 1'b0;
            cand_code  <= '0;
            ratio_code <= '0;
            bit_ref    <= '0;
            resync     <= 1'b0;
        end else begin
            resync <= 1'b0;
            if (init_done) begin
                case (state)
                    DET_ACQUIRE: begin
                        if (word_rise) begin
                            have_ref <= 1'b1;
                            if (have_ref) begin
                                if (!match_valid) begin
                                    cand_valid <= 1'b0;
                                end else if (cand_valid && (cand_code == match_code)) begin
                                    state      <= DET_LOCKED;
                                    ratio_code <= match_code;
                                    bit_ref    <= bit_cnt;
                                    cand_valid <= 1'b0;
                                end else begin
                                    cand_valid <= 1'b1;
                                    cand_code  <= match_code;
                                end
                            end
                        end
                    end
                    DET_LOCKED: begin
                        if (word_rise) begin
                            if (drift_bad) begin
                                state      <= DET_ACQUIRE;
                                resync     <= 1'b1;
                                cand_valid <= 1'b0;
                                have_ref   <= 1'b1;
                            end
                        end else if (late_bad) begin
                            state      <= DET_ACQUIRE;
                            resync     <= 1'b1;
                            cand_valid <= 1'b0;
                            have_ref   <= 1'b0;
                        end
                    end
                    default: state <= DET_ACQUIRE;
                endcase
            end
        end
    end

    AST_LOCK_AFTER_INIT: assert property (@(posedge clk) disable iff (!rst_n) locked |-> init_done); // R1
    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n) locked |-> (ratio_code < CODE_W'(NUM_RATIOS))); // R2
    AST_LOCK_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n) $rose(locked) |-> $past(word_rise && match_valid)); // R3
    AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n) locked |=> (!locked || $stable(ratio_code))); // R3
    AST_DRIFT_TOLERATED: assert property (@(posedge clk) disable iff (!rst_n) (locked && word_rise && (bit_cnt == bit_ref)) |=> locked); // R6
    AST_RESYNC_PULSE: assert property (@(posedge clk) disable iff (!rst_n) resync |=> !resync); // R8
    AST_RESYNC_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n) resync |-> !locked); // R8
endmodule

// File: rtl/audio_clk_ratio_det.sv
// Audio clock ratio detector top: start-up sequencer, frame meter, ratio
// matcher and lock controller. Assumes word and bit clocks are synchronous
// to clk and slower than half its rate.
module audio_clk_ratio_det #(
    parameter int BASE_RATIO  = 128,
    parameter int MATCH_TOL   = 2,
    parameter int INIT_CYCLES = 1024,
    parameter int DRIFT_BITS  = 6,
    parameter int BIT_W       = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       word_clk,
    input  logic       bit_clk,
    output logic [2:0] ratio_code,
    output logic       ratio_ready,
    output logic       force_mid,
    output logic       resync_pulse
);
    import acd_pkg::*;

    localparam int RATIO_MAX = ratio_of(BASE_RATIO, NUM_RATIOS - 1);
    localparam int PER_LIMIT = RATIO_MAX + MATCH_TOL;
    localparam int PER_W     = $clog2(2 * RATIO_MAX + 1);

    logic             init_done;
    logic             word_rise;
    logic [PER_W-1:0] per_cnt;
    logic [BIT_W-1:0] bit_cnt;
    logic             match_valid;
    ratio_code_t      match_code;
    logic             locked;
    ratio_code_t      code_q;

    acd_init_seq #(.INIT_CYCLES(INIT_CYCLES)) u_init (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_done (init_done)
    );

    acd_frame_meter #(.PER_W(PER_W), .BIT_W(BIT_W)) u_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (init_done),
        .word_clk  (word_clk),
        .bit_clk   (bit_clk),
        .word_rise (word_rise),
        .per_cnt   (per_cnt),
        .bit_cnt   (bit_cnt)
    );

    acd_ratio_match #(.BASE_RATIO(BASE_RATIO), .TOL(MATCH_TOL), .PER_W(PER_W)) u_match (
        .per_cnt     (per_cnt),
        .match_valid (match_valid),
        .match_code  (match_code)
    );

    acd_lock_ctrl #(
        .PER_W      (PER_W),
        .BIT_W      (BIT_W),
        .DRIFT_BITS (DRIFT_BITS),
        .PER_LIMIT  (PER_LIMIT)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .init_done   (init_done),
        .word_rise   (word_rise),
        .per_cnt     (per_cnt),
        .bit_cnt     (bit_cnt),
        .match_valid (match_valid),
        .match_code  (match_code),
        .locked      (locked),
        .ratio_code  (code_q),
        .resync      (resync_pulse)
    );

    assign ratio_code  = code_q;
    assign ratio_ready = locked;
    assign force_mid   = ~locked;
endmodule

// File: tb/audio_clk_ratio_det_tb.sv
`timescale 1ns/1ps
module audio_clk_ratio_det_tb_top;
    localparam int WD_CYCLES = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       word_clk = 1'b0;
    logic       bit_clk = 1'b0;
    logic [2:0] ratio_code;
    logic       ratio_ready;
    logic       force_mid;
    logic       resync_pulse;

    always #10 clk = ~clk;

    audio_clk_ratio_det dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .word_clk     (word_clk),
        .bit_clk      (bit_clk),
        .ratio_code   (ratio_code),
        .ratio_ready  (ratio_ready),
        .force_mid    (force_mid),
        .resync_pulse (resync_pulse)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int n_rs  = 0;
    bit done  = 1'b0;
    bit mon_en = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Stimulus generator: word clock of g_len cycles, bit clock of g_bp cycles.
    int g_len = 256, g_next = 256, g_bp = 4, g_ph = 0, g_skip = 0;
    bit g_hold_w = 1'b0, g_freeze = 1'b0, g_alt = 1'b0;
    always @(negedge clk) begin
        if (!g_freeze) begin
            word_clk = g_hold_w ? 1'b0 : (g_ph < g_len / 2);
            bit_clk  = (g_ph % g_bp) >= (g_bp / 2);
            g_ph     = g_ph + 1 + g_skip;
            g_skip   = 0;
            if (g_ph >= g_len) begin
                g_ph = 0;
                if (g_alt) g_len = (g_len == 256) ? 384 : 256;
                else       g_len = g_next;
            end
        end
    end

    // Behavioural reference model, advanced at every rising clock edge.
    int m_icnt, m_per, m_bits, m_cand, m_code, m_bref;
    bit m_idone, m_pw, m_pb, m_ref, m_cv, m_lock, m_rs;

    function automatic int classify(input int p);
        int table_r[6] = '{128, 192, 256, 384, 512, 768};
        for (int i = 0; i < 6; i++) begin
            if (p >= table_r[i] - 2 && p <= table_r[i] + 2) return i;
        end
        return -1;
    endfunction

    always @(posedge clk) begin : model
        bit wr, br;
        int c, d;
        if (!rst_n) begin
            m_icnt = 0; m_idone = 0; m_pw = 0; m_pb = 0; m_per = 0; m_bits = 0;
            m_ref = 0; m_cv = 0; m_cand = 0; m_lock = 0; m_code = 0; m_bref = 0; m_rs = 0;
        end else begin
            wr = word_clk && !m_pw;
            br = bit_clk && !m_pb;
            m_pw = word_clk;
            m_pb = bit_clk;
            m_rs = 0;
            if (!m_idone) begin
                if (m_icnt == 1023) m_idone = 1; else m_icnt++;
                m_per = 0;
                m_bits = 0;
            end else begin
                if (!m_lock) begin
                    if (wr) begin
                        if (m_ref) begin
                            c = classify(m_per);
                            if (c < 0) m_cv = 0;
                            else if (m_cv && m_cand == c) begin
                                m_lock = 1; m_code = c; m_bref = m_bits; m_cv = 0;
                            end else begin
                                m_cv = 1; m_cand = c;
                            end
                        end
                        m_ref = 1;
                    end
                end else begin
                    d = (m_bits > m_bref) ? m_bits - m_bref : m_bref - m_bits;
                    if (wr) begin
                        if (d > 6) begin m_lock = 0; m_rs = 1; m_cv = 0; m_ref = 1; end
                    end else if (m_bits > m_bref + 6 || m_per > 770) begin
                        m_lock = 0; m_rs = 1; m_cv = 0; m_ref = 0;
                    end
                end
                if (wr) begin
                    m_per = 1;
                    m_bits = br ? 1 : 0;
                end else begin
                    if (m_per < 2047) m_per++;
                    if (br && m_bits < 255) m_bits++;
                end
            end
        end
    end

    // Cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (resync_pulse) n_rs++;
        if (mon_en) begin
            chk("R2 ratio_code vs model", int'(ratio_code), m_code);
            chk("R3 ratio_ready vs model", int'(ratio_ready), int'(m_lock));
            chk("R5 force_mid vs model", int'(force_mid), int'(!m_lock));
            chk("R8 resync_pulse vs model", int'(resync_pulse), int'(m_rs));
        end
    end

    task automatic run(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic set_clock(input int len, input int bp);
        @(posedge clk);
        g_len = len; g_next = len; g_bp = bp; g_ph = 0; g_alt = 0;
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        run(3);
        @(negedge clk);
        chk("R9 ready cleared by reset", int'(ratio_ready), 0);
    endtask

    task automatic release_reset();
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic expect_lock(input string tag, input int ready, input int code);
        @(negedge clk);
        chk(tag, int'(ratio_ready), ready);
        if (ready == 1) chk(tag, int'(ratio_code), code);
        chk("R5 force_mid mirrors ready", int'(force_mid), int'(!ready));
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    int rs0;

    initial begin
        run(2);
        mon_en = 1'b1;
        run(3);
        @(negedge clk);
        chk("R1 reset ready", int'(ratio_ready), 0);
        chk("R1 reset force_mid", int'(force_mid), 1);
        chk("R1 reset code", int'(ratio_code), 0);
        chk("R1 reset resync", int'(resync_pulse), 0);
        release_reset();
        run(1000);
        expect_lock("R1 still initialising", 0, 0);
        run(1100);
        expect_lock("R3 lock at 256", 1, 2);

        // Six bit periods of drift is tolerated.
        rs0 = n_rs;
        while (g_ph != 20) @(posedge clk);
        g_skip = 24;
        run(600);
        expect_lock("R6 drift of 6 kept", 1, 2);
        chk("R6 no resync for 6", n_rs, rs0);

        // Seven bit periods drops the lock at the next edge.
        while (g_ph != 20) @(posedge clk);
        g_skip = 28;
        run(300);
        expect_lock("R6 drift of 7 drops", 0, 0);
        chk("R8 one resync pulse", n_rs, rs0 + 1);
        run(700);
        expect_lock("R8 relock without init", 1, 2);

        // Word clock held low while bit clock runs.
        rs0 = n_rs;
        @(posedge clk) g_hold_w = 1'b1;
        run(400);
        expect_lock("R7 missing word edge", 0, 0);
        chk("R7 resync on late edge", n_rs, rs0 + 1);
        @(posedge clk) g_hold_w = 1'b0;
        run(1200);
        expect_lock("R8 relock after hold", 1, 2);

        // Both clocks frozen: frame timeout.
        rs0 = n_rs;
        @(posedge clk) g_freeze = 1'b1;
        run(900);
        expect_lock("R7 frozen clocks", 0, 0);
        chk("R7 resync on timeout", n_rs, rs0 + 1);
        @(posedge clk) g_freeze = 1'b0;
        run(1200);
        expect_lock("R7 relock after freeze", 1, 2);

        // Every ratio, each after a reset.
        for (int i = 0; i < 6; i++) begin
            int r;
            r = ((i % 2) == 0) ? (128 << (i / 2)) : (192 << (i / 2));
            do_reset();
            set_clock(r, r / 64);
            release_reset();
            run(1000);
            expect_lock("R9 init rerun after reset", 0, 0);
            run(1024 + 4 * r);
            expect_lock("R2 ratio code per ratio", 1, i);
        end

        // Tolerance window edges.
        do_reset(); set_clock(126, 2); release_reset(); run(2000);
        expect_lock("R2 lower window edge 126", 1, 0);
        do_reset(); set_clock(258, 4); release_reset(); run(2200);
        expect_lock("R2 upper window edge 258", 1, 2);
        do_reset(); set_clock(259, 4); release_reset(); run(3000);
        expect_lock("R4 259 unsupported", 0, 0);
        do_reset(); set_clock(300, 4); release_reset(); run(3000);
        expect_lock("R4 300 unsupported", 0, 0);

        // Alternating frames never agree twice.
        do_reset(); set_clock(256, 4);
        @(posedge clk) g_alt = 1'b1;
        release_reset(); run(4000);
        expect_lock("R3 alternating frames", 0, 0);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        run(WD_CYCLES);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end
endmodule